// File: doc/BRIEF.md
# Bit-Sliced 320-Bit SP-Network Round Engine

This block runs a keyless 320-bit substitution-permutation network at one round per clock. The state is five 64-bit words x0..x4. Each round does three things in order. It XORs an 8-bit round constant into x2. It passes every one of the 64 bit columns through a 5-bit degree-2 substitution box. It then diffuses each word with its own pair of right rotations.

A controller loads a 320-bit state and pulses `start` with a round count. The engine goes busy and steps through the tail of a 12-entry constant schedule. It then raises `done` for one cycle with the final state on `state_out`. That state stays there until the next accepted start. The engine does not sequence cipher modes and does not mask the state; the surrounding logic does both.

Top module: `sp_round_unit`

## Requirements
- R1: While reset is held and after its release, `state_out` is all zeros and `busy` and `done` are low, until the first accepted start.
- R2: A `start` sampled high while `busy` is low loads `state_in` and begins a run. `busy` is high from the next cycle through the cycle of the last round.
- R3: For a run of n rounds accepted at clock edge k, the final state appears and `done` is high after edge k+n. `done` lasts exactly one cycle. `busy` is low in that cycle.
- R4: Round i of the 12-entry schedule (i = 0..11) XORs the constant ((15 - i) << 4) | i into bits 7:0 of x2 before substitution. A run of n rounds uses i = 12 - n up to 11.
- R5: The substitution acts on each bit position j separately, taking bit j of x0..x4 as a 5-bit input. The steps are: x0^=x4, x4^=x3, x2^=x1; then t_k = ~x_k & x_(k+1 mod 5) and x_k ^= t_(k+1 mod 5); then x1^=x0, x0^=x4, x3^=x2, x2=~x2.
- R6: After substitution, each word w is replaced by w XOR rotr(w,a) XOR rotr(w,b), rotating right within 64 bits. The pairs (a,b) are x0:(19,28), x1:(61,39), x2:(1,6), x3:(10,17), x4:(7,41).
- R7: `rounds_in` gives the run length n for values 1 to 12. The supported counts are 6, 8 and 12. The value 0 and the values 13 to 15 run 12 rounds.
- R8: A `start` sampled while `busy` is high is ignored. The run in progress keeps its length and its result.
- R9: While idle with no start, `state_out` holds its last value whatever `state_in` does.
- R10: The state vectors are packed with x0 in bits 319:256, x1 in 255:192, x2 in 191:128, x3 in 127:64 and x4 in 63:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run when idle |
| rounds_in | input | 4 | Requested round count |
| state_in | input | 320 | State loaded on an accepted start |
| state_out | output | 320 | Working state; final result after done |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse when the last round is written |

## Verification
A start that is accepted at edge k makes `busy` visible one edge later. The final state and `done` are due exactly n edges after k, and `done` must be low again one edge after that. The bench drives inputs and samples outputs on falling edges. It counts falling edges from the start edge and checks the final state and `done` at count n only, with `busy` checked at each count before it. The idle hold and the ignored start are checked on the cycles right after the pulse, and during the run.

// File: rtl/sp_round_pkg.sv
package sp_round_pkg;

   localparam int NUM_WORDS = 5;
   localparam int LANE_W    = 64;
   localparam int RC_W      = 8;
   localparam int RC_WORD   = 2;

   // Right-rotation pair per word for the diffusion layer.
   function automatic int rot_amt(input int word, input int sel);
      int r;
      case (word)
         0:       r = (sel == 0) ? 19 : 28;
         1:       r = (sel == 0) ? 61 : 39;
         2:       r = (sel == 0) ? 1  : 6;
         3:       r = (sel == 0) ? 10 : 17;
         default: r = (sel == 0) ? 7  : 41;
      endcase
      return r;
   endfunction

   // 5-bit degree-2 substitution on one bit column; bit k is word xk.
   function automatic logic [NUM_WORDS-1:0] sbox5(input logic [NUM_WORDS-1:0] a);
      logic [NUM_WORDS-1:0] b;
      logic [NUM_WORDS-1:0] t;
      logic [NUM_WORDS-1:0] c;
      b    = a;
      b[0] = a[0] ^ a[4];
      b[4] = a[4] ^ a[3];
      b[2] = a[2] ^ a[1];
      for (int k = 0; k < NUM_WORDS; k++)
         t[k] = ~b[k] & b[(k + 1) % NUM_WORDS];
      for (int k = 0; k < NUM_WORDS; k++)
         c[k] = b[k] ^ t[(k + 1) % NUM_WORDS];
      c[1] = c[1] ^ c[0];
      c[0] = c[0] ^ c[4];
      c[3] = c[3] ^ c[2];
      c[2] = ~c[2];
      return c;
   endfunction

endpackage

// File: rtl/sp_round_const.sv
module sp_round_const #(
   parameter int IDX_W   = 4,
   parameter int CONST_W = 8
) (
   input  logic [IDX_W-1:0]   idx,
   output logic [CONST_W-1:0] rc
);
   localparam int HALF = CONST_W / 2;

   if (IDX_W > HALF) begin : g_bad_width
      $error("sp_round_const: IDX_W must fit in half of CONST_W");
   end

   logic [HALF-1:0] lo;
   logic [HALF-1:0] hi;

   assign lo = HALF'(idx);
   // all-ones minus the index: the upper nibble counts down as lo counts up
   assign hi = {HALF{1'b1}} - lo;
   assign rc = {hi, lo};

endmodule

// File: rtl/sp_subst_layer.sv
module sp_subst_layer
   import sp_round_pkg::*;
#(
   parameter int WORD_W = 64
) (
   input  logic [NUM_WORDS-1:0][WORD_W-1:0] x_in,
   output logic [NUM_WORDS-1:0][WORD_W-1:0] x_out
);

   for (genvar j = 0; j < WORD_W; j++) begin : g_col
      logic [NUM_WORDS-1:0] col_in;
      logic [NUM_WORDS-1:0] col_out;
      for (genvar k = 0; k < NUM_WORDS; k++) begin : g_gather
         assign col_in[k] = x_in[k][j];
      end
      assign col_out = sbox5(col_in);
      for (genvar k = 0; k < NUM_WORDS; k++) begin : g_scatter
         assign x_out[k][j] = col_out[k];
      end
   end

endmodule

// File: rtl/sp_diffuse_layer.sv
module sp_diffuse_layer
   import sp_round_pkg::*;
#(
   parameter int WORD_W = 64
) (
   input  logic [NUM_WORDS-1:0][WORD_W-1:0] x_in,
   output logic [NUM_WORDS-1:0][WORD_W-1:0] x_out
);

   function automatic logic [WORD_W-1:0] rotr(input logic [WORD_W-1:0] v, input int r);
      return (v >> r) | (v << (WORD_W - r));
   endfunction

   for (genvar k = 0; k < NUM_WORDS; k++) begin : g_word
      localparam int ROT_A = rot_amt(k, 0);
      localparam int ROT_B = rot_amt(k, 1);
      if (ROT_A <= 0 || ROT_A >= WORD_W || ROT_B <= 0 || ROT_B >= WORD_W) begin : g_bad_rot
         $error("sp_diffuse_layer: rotation out of range for word width");
      end
      assign x_out[k] = x_in[k] ^ rotr(x_in[k], ROT_A) ^ rotr(x_in[k], ROT_B);
   end

endmodule

// File: rtl/sp_round_unit.sv
module sp_round_unit
   import sp_round_pkg::*;
#(
   parameter  int WORD_W     = 64,
   parameter  int MAX_ROUNDS = 12,
   localparam int STATE_W    = NUM_WORDS * WORD_W,
   localparam int CNT_W      = $clog2(MAX_ROUNDS + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [CNT_W-1:0]   rounds_in,
   input  logic [STATE_W-1:0] state_in,
   output logic [STATE_W-1:0] state_out,
   output logic               busy,
   output logic               done
);

   if (WORD_W != LANE_W) begin : g_bad_word
      $error("sp_round_unit: rotation schedule is defined for 64-bit words only");
   end
   if (MAX_ROUNDS < 1 || MAX_ROUNDS > 16) begin : g_bad_rounds
      $error("sp_round_unit: MAX_ROUNDS must be 1..16 for the constant schedule");
   end

   localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(MAX_ROUNDS - 1);
   localparam logic [CNT_W-1:0] FULL_RUN = CNT_W'(MAX_ROUNDS);

   logic [STATE_W-1:0] state_q;
   logic [STATE_W-1:0] state_nxt;
   logic [CNT_W-1:0]   idx_q;
   logic               busy_q;
   logic               done_q;

   logic [CNT_W-1:0]   run_len;
   logic [CNT_W-1:0]   first_idx;
   logic [RC_W-1:0]    rc;

   logic [NUM_WORDS-1:0][WORD_W-1:0] w_cur;
   logic [NUM_WORDS-1:0][WORD_W-1:0] w_add;
   logic [NUM_WORDS-1:0][WORD_W-1:0] w_sub;
   logic [NUM_WORDS-1:0][WORD_W-1:0] w_lin;

   // x0 occupies the top word of the packed vector
   for (genvar k = 0; k < NUM_WORDS; k++) begin : g_pack
      assign w_cur[k] = state_q[STATE_W-1-k*WORD_W -: WORD_W];
      assign state_nxt[STATE_W-1-k*WORD_W -: WORD_W] = w_lin[k];
   end

   // out-of-range counts fall back to the full schedule
   always_comb begin
      if (rounds_in == '0 || rounds_in > FULL_RUN) run_len = FULL_RUN;
      else                                         run_len = rounds_in;
      first_idx = FULL_RUN - run_len;
   end

   sp_round_const #(
      .IDX_W   (CNT_W),
      .CONST_W (RC_W)
   ) u_const (
      .idx (idx_q),
      .rc  (rc)
   );

   always_comb begin
      w_add = w_cur;
      w_add[RC_WORD][RC_W-1:0] = w_cur[RC_WORD][RC_W-1:0] ^ rc;
   end

   sp_subst_layer #(
      .WORD_W (WORD_W)
   ) u_sub (
      .x_in  (w_add),
      .x_out (w_sub)
   );

   sp_diffuse_layer #(
      .WORD_W (WORD_W)
   ) u_lin (
      .x_in  (w_sub),
      .x_out (w_lin)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= '0;
         idx_q   <= '0;
         busy_q  <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (!busy_q) begin
            if (start) begin
               state_q <= state_in;
               idx_q   <= first_idx;
               busy_q  <= 1'b1;
            end
         end else begin
            state_q <= state_nxt;
            if (idx_q == LAST_IDX) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
            end else begin
               idx_q <= idx_q + 1'b1;
            end
         end
      end
   end

   assign state_out = state_q;
   assign busy      = busy_q;
   assign done      = done_q;

endmodule

// File: rtl/sp_round_unit_chk.sv
module sp_round_unit_chk #(
   parameter int MAX_ROUNDS = 12,
   parameter int CNT_W      = 4,
   parameter int STATE_W    = 320
) (
   input logic               clk,
   input logic               rst_n,
   input logic               start,
   input logic               busy,
   input logic               done,
   input logic [STATE_W-1:0] state_out
);

   // consecutive busy cycles seen so far
   logic [CNT_W-1:0] busy_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    busy_cnt <= '0;
      else if (busy) busy_cnt <= busy_cnt + 1'b1;
      else           busy_cnt <= '0;
   end

   p_accept_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);

   p_done_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_done_at_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

   p_done_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   p_run_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (busy_cnt < CNT_W'(MAX_ROUNDS)));

   p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> $stable(state_out));

endmodule

bind sp_round_unit sp_round_unit_chk #(
   .MAX_ROUNDS (MAX_ROUNDS),
   .CNT_W      (CNT_W),
   .STATE_W    (STATE_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .busy      (busy),
   .done      (done),
   .state_out (state_out)
);

// File: tb/sim_sp_round_unit.sv
module sim_sp_round_unit;

   localparam int CLK_PERIOD = 10;
   localparam int SW = 320;

   logic          clk = 1'b0;
   logic          rst_n = 1'b1;
   logic          start = 1'b0;
   logic [3:0]    rounds_in = 4'd0;
   logic [SW-1:0] state_in = '0;
   logic [SW-1:0] state_out;
   logic          busy;
   logic          done;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sp_round_unit u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .rounds_in (rounds_in),
      .state_in  (state_in),
      .state_out (state_out),
      .busy      (busy),
      .done      (done)
   );

   function automatic logic [63:0] rr(input logic [63:0] v, input int r);
      return (v >> r) | (v << (64 - r));
   endfunction

   function automatic logic [SW-1:0] ref_round(input logic [SW-1:0] s, input int i);
      logic [63:0] x0, x1, x2, x3, x4, t0, t1, t2, t3, t4;
      x0 = s[319:256]; x1 = s[255:192]; x2 = s[191:128]; x3 = s[127:64]; x4 = s[63:0];
      x2 = x2 ^ {56'd0, 8'(((15 - i) << 4) | i)};
      x0 ^= x4; x4 ^= x3; x2 ^= x1;
      t0 = ~x0 & x1; t1 = ~x1 & x2; t2 = ~x2 & x3; t3 = ~x3 & x4; t4 = ~x4 & x0;
      x0 ^= t1; x1 ^= t2; x2 ^= t3; x3 ^= t4; x4 ^= t0;
      x1 ^= x0; x0 ^= x4; x3 ^= x2; x2 = ~x2;
      x0 = x0 ^ rr(x0, 19) ^ rr(x0, 28);
      x1 = x1 ^ rr(x1, 61) ^ rr(x1, 39);
      x2 = x2 ^ rr(x2, 1)  ^ rr(x2, 6);
      x3 = x3 ^ rr(x3, 10) ^ rr(x3, 17);
      x4 = x4 ^ rr(x4, 7)  ^ rr(x4, 41);
      return {x0, x1, x2, x3, x4};
   endfunction

   function automatic int eff_len(input logic [3:0] n);
      return (n == 0 || n > 12) ? 12 : int'(n);
   endfunction

   function automatic logic [SW-1:0] ref_perm(input logic [SW-1:0] s, input logic [3:0] n);
      logic [SW-1:0] v = s;
      for (int i = 12 - eff_len(n); i < 12; i++) v = ref_round(v, i);
      return v;
   endfunction

   function automatic logic [SW-1:0] rand_state();
      logic [SW-1:0] r = '0;
      for (int q = 0; q < 10; q++) r = {r[SW-33:0], 32'($urandom())};
      return r;
   endfunction

   task automatic chk(input string req, input logic [SW-1:0] act, input logic [SW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // Runs one permutation; poke drives a second start during the run.
   task automatic run_case(input logic [3:0] n_in, input logic [SW-1:0] s,
                           input bit poke, input string req, output logic [SW-1:0] res);
      logic [SW-1:0] exp = ref_perm(s, n_in);
      int n = eff_len(n_in);
      bit busy_ok = 1'b1;
      @(negedge clk);
      start = 1'b1; rounds_in = n_in; state_in = s;
      @(negedge clk);
      start = poke; rounds_in = 4'd1; state_in = rand_state();
      if (busy !== 1'b1 || done !== 1'b0) busy_ok = 1'b0;
      for (int j = 1; j <= n; j++) begin
         @(negedge clk);
         start = 1'b0;
         if (j < n) begin
            if (busy !== 1'b1 || done !== 1'b0) busy_ok = 1'b0;
         end else begin
            chk("R3 done at n", {319'd0, done}, {319'd0, 1'b1});
            chk("R3 busy low at done", {319'd0, busy}, '0);
            chk(req, state_out, exp);
         end
      end
      chk("R2 busy through run", {319'd0, busy_ok}, {319'd0, 1'b1});
      @(negedge clk);
      chk("R3 single pulse", {319'd0, done}, '0);
      res = exp;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [SW-1:0] res;
      logic [SW-1:0] s;
      logic [3:0] n;
      void'($urandom(32'd7321));
      #1 rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk("R1 reset state", state_out, '0);
      chk("R1 reset flags", {318'd0, busy, done}, '0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 after release", {state_out[317:0], busy, done}, '0);

      run_case(4'd12, '0, 1'b0, "R5 R6 zero state 12 rounds", res);
      run_case(4'd1, '0, 1'b0, "R4 single last round constant", res);
      run_case(4'd6, {SW{1'b1}}, 1'b0, "R7 six rounds all ones", res);
      run_case(4'd8, {64'd0, 64'd1 << 37, 192'd0}, 1'b0, "R5 R10 one bit in x1 eight rounds", res);
      run_case(4'd0, rand_state(), 1'b0, "R7 count 0 runs 12", res);
      run_case(4'd15, rand_state(), 1'b0, "R7 count 15 runs 12", res);
      run_case(4'd6, rand_state(), 1'b1, "R8 start while busy ignored", res);

      // R9: idle hold against a moving state_in
      for (int h = 0; h < 4; h++) begin
         state_in = rand_state();
         @(negedge clk);
         chk("R9 idle hold", state_out, res);
      end

      for (int r = 0; r < 24; r++) begin
         case ($urandom() % 3)
            0:       n = 4'd6;
            1:       n = 4'd8;
            default: n = 4'd12;
         endcase
         s = rand_state();
         run_case(n, s, (r % 5) == 0, "R4 R10 random run", res);
      end

      finished = 1'b1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule